// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one character at a time into an asynchronous serial frame. A frame is a low start bit, then 4 to 16 data bits, then an optional parity bit, then a stop period held high. The frame format is set by static configuration inputs, which are captured when a character is accepted. Timing comes from an external baud-tick enable, and each bit lasts a fixed number of ticks (16 by default).

Characters enter through a valid/ready handshake. Each character carries three flags. The first sends the frame as a break. The second releases the line driver once the frame ends. The third turns the transmitter off once the frame ends. The block drives the serial line, an output-enable for the pad, a one-cycle completion pulse and the current enable state. The transmitter starts disabled after reset and is switched on by a one-cycle command input.

Top module: `async_frame_tx`

## Requirements
- R1: After reset the line is high (`tx_out`=1 with no inversion), `tx_oe`=1, `tx_enabled`=0, `in_ready`=0 and `tx_done`=0. A frame is a low start bit, then data bits, then an optional parity bit, then a high stop period. With `cfg_msb_first`=0 the data goes out least significant bit first. `in_ready` is high only while the transmitter is enabled and no frame is in progress.
- R2: `cfg_len_code` values 1 to 13 select 4 to 16 data bits: the bit count is the code plus 3. Bits of `in_data` above the selected length are not sent.
- R3: `cfg_len_code` values 0, 14 and 15 select 8 data bits.
- R4: `cfg_parity` code 0 adds no parity bit. Code 2 adds an even parity bit, so the total number of ones over data and parity is even. Code 3 adds an odd parity bit. Code 1 behaves as code 0.
- R5: `cfg_stop` sets the stop period in baud ticks: code 0 gives 8 ticks, code 1 gives 16, code 2 gives 24 and code 3 gives 32.
- R6: The start, data and parity bits each last 16 baud ticks. Clock cycles with `baud_tick`=0 do not advance the frame.
- R7: With `cfg_msb_first`=1 the data bits go out most significant bit first, counted within the selected length.
- R8: `cfg_invert`=1 inverts `tx_out` at all times, including when the line is idle.
- R9: A character accepted with `in_break`=1 holds the line low for the whole frame, including the stop period. Its data bits are ignored.
- R10: A character accepted with `in_tri_after`=1 drops `tx_oe` in the same cycle as its `tx_done`. `tx_oe` returns high when the next character is accepted.
- R11: A character accepted with `in_dis_after`=1 clears `tx_enabled` in the same cycle as its `tx_done`. While the transmitter is disabled, `in_valid` is ignored and the line stays idle. A pulse on `tx_en_set` enables the transmitter again.
- R12: `tx_done` is high for exactly one cycle: the cycle after the baud tick that ends the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick enable |
| tx_en_set | input | 1 | One-cycle command that enables the transmitter |
| cfg_len_code | input | 4 | Data-length code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop-period code |
| cfg_msb_first | input | 1 | Send the most significant data bit first |
| cfg_invert | input | 1 | Invert the serial output |
| in_valid | input | 1 | Character valid |
| in_ready | output | 1 | Transmitter can accept a character |
| in_data | input | 16 | Character bits |
| in_break | input | 1 | Send this frame as a break |
| in_tri_after | input | 1 | Release the line driver after this frame |
| in_dis_after | input | 1 | Disable the transmitter after this frame |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Line driver enable (0 = tristate) |
| tx_done | output | 1 | Frame complete pulse |
| tx_enabled | output | 1 | Transmitter enable state |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and a 16-bit data path. With these values every length code from 4 up to the full 16 bits can be driven, and the 8-tick half-stop granularity is visible. The bench checks the line one baud tick at a time. In one scenario it spaces the ticks three cycles apart, which shows that idle cycles do not advance the frame. The enable and tristate flags are checked in the cycle that completes the frame.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

    localparam int MAX_DATA   = 16;
    localparam int NBITS_W    = $clog2(MAX_DATA + 1);
    localparam int LEN_MIN    = 4;
    localparam int LEN_DEF    = 8;
    localparam int LEN_CODE_HI = MAX_DATA - LEN_MIN + 1;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_RSVD = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [MAX_DATA-1:0] bits;      // already in transmit order, bit 0 first
        logic [NBITS_W-1:0]  nbits;
        logic                par_en;
        logic                par_val;
        logic [1:0]          stop_code;
    } frame_plan_t;

    typedef struct packed {
        logic brk;
        logic tri_after;
        logic dis_after;
    } frame_flags_t;

    function automatic logic [NBITS_W-1:0] decode_len(input logic [3:0] code);
        if (code >= 4'd1 && int'(code) <= LEN_CODE_HI)
            return NBITS_W'(int'(code) + LEN_MIN - 1);
        return NBITS_W'(LEN_DEF);
    endfunction

    function automatic logic [MAX_DATA-1:0] bit_reverse(input logic [MAX_DATA-1:0] v);
        logic [MAX_DATA-1:0] r;
        for (int i = 0; i < MAX_DATA; i++) r[i] = v[MAX_DATA-1-i];
        return r;
    endfunction

endpackage

// File: rtl/aftx_framer.sv
module aftx_framer
    import aftx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic [3:0]          len_code,
    input  logic [1:0]          par_code,
    input  logic [1:0]          stop_code,
    input  logic                msb_first,
    output frame_plan_t         plan
);

    logic [NBITS_W-1:0]  nb;
    logic [NBITS_W-1:0]  unused_w;
    logic [MAX_DATA-1:0] mask;
    logic [MAX_DATA-1:0] masked;
    logic [MAX_DATA-1:0] reversed;
    par_mode_e           pm;

    always_comb begin
        nb       = decode_len(len_code);
        unused_w = NBITS_W'(MAX_DATA) - nb;
        mask     = {MAX_DATA{1'b1}} >> unused_w;
        masked   = data & mask;
        reversed = bit_reverse(masked) >> unused_w;
        pm       = par_mode_e'(par_code);

        plan.nbits     = nb;
        plan.bits      = msb_first ? reversed : masked;
        plan.par_en    = (pm == PAR_EVEN) || (pm == PAR_ODD);
        plan.par_val   = (^masked) ^ (pm == PAR_ODD);
        plan.stop_code = stop_code;
    end

endmodule

// File: rtl/aftx_bit_timer.sv
module aftx_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             baud_tick,
    input  logic [CNT_W-1:0] limit,
    output logic             seg_end
);

    logic [CNT_W-1:0] cnt;

    assign seg_end = baud_tick && !restart && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (baud_tick)
            cnt <= seg_end ? '0 : cnt + CNT_W'(1);
    end

    // R6: the tick count never runs past the segment length
    assert_tick_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/aftx_line_ctrl.sv
module aftx_line_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_set,
    input  logic accept,
    input  logic frame_end,
    input  logic flag_tri,
    input  logic flag_dis,
    output logic enabled,
    output logic oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b0;
            oe      <= 1'b1;
        end else begin
            if (en_set)
                enabled <= 1'b1;
            else if (frame_end && flag_dis)
                enabled <= 1'b0;

            if (accept)
                oe <= 1'b1;
            else if (frame_end && flag_tri)
                oe <= 1'b0;
        end
    end

    // R10: the driver is released only as a frame closes
    assert_oe_release_at_end_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> $past(frame_end));

    // R11: a frame cannot start while disabled
    assert_no_accept_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        accept |-> enabled);

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aftx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                baud_tick,
    input  logic                tx_en_set,
    input  logic [3:0]          cfg_len_code,
    input  logic [1:0]          cfg_parity,
    input  logic [1:0]          cfg_stop,
    input  logic                cfg_msb_first,
    input  logic                cfg_invert,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MAX_DATA-1:0] in_data,
    input  logic                in_break,
    input  logic                in_tri_after,
    input  logic                in_dis_after,
    output logic                tx_out,
    output logic                tx_oe,
    output logic                tx_done,
    output logic                tx_enabled
);

    localparam int CNT_W      = $clog2(2 * TICKS_PER_BIT + 1);
    localparam int HALF_TICKS = TICKS_PER_BIT / 2;

    tx_state_e           state;
    frame_plan_t         plan_d, plan_q;
    frame_flags_t        flags_q;
    logic [MAX_DATA-1:0] shreg;
    logic [NBITS_W-1:0]  bit_idx;
    logic [CNT_W-1:0]    limit;
    logic                seg_end;
    logic                accept;
    logic                frame_end;
    logic                level;
    logic                done_q;

    aftx_framer u_framer (
        .data      (in_data),
        .len_code  (cfg_len_code),
        .par_code  (cfg_parity),
        .stop_code (cfg_stop),
        .msb_first (cfg_msb_first),
        .plan      (plan_d)
    );

    assign in_ready  = (state == ST_IDLE) && tx_enabled;
    assign accept    = in_valid && in_ready;
    assign frame_end = (state == ST_STOP) && seg_end;

    always_comb begin
        if (state == ST_STOP)
            limit = CNT_W'(HALF_TICKS * (int'(plan_q.stop_code) + 1));
        else
            limit = CNT_W'(TICKS_PER_BIT);
    end

    aftx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .baud_tick (baud_tick),
        .limit     (limit),
        .seg_end   (seg_end)
    );

    aftx_line_ctrl u_line (
        .clk       (clk),
        .rst       (rst),
        .en_set    (tx_en_set),
        .accept    (accept),
        .frame_end (frame_end),
        .flag_tri  (flags_q.tri_after),
        .flag_dis  (flags_q.dis_after),
        .enabled   (tx_enabled),
        .oe        (tx_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            plan_q  <= '0;
            flags_q <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state   <= ST_START;
                plan_q  <= plan_d;
                shreg   <= plan_d.bits;
                flags_q <= '{brk: in_break, tri_after: in_tri_after, dis_after: in_dis_after};
                bit_idx <= '0;
            end else if (seg_end) begin
                unique case (state)
                    ST_START: begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == plan_q.nbits - NBITS_W'(1))
                            state <= plan_q.par_en ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + NBITS_W'(1);
                    end
                    ST_PAR:  state <= ST_STOP;
                    ST_STOP: begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  level = 1'b1;
            ST_START: level = 1'b0;
            ST_DATA:  level = shreg[0];
            ST_PAR:   level = plan_q.par_val;
            ST_STOP:  level = 1'b1;
            default:  level = 1'b1;
        endcase
        if (state != ST_IDLE && flags_q.brk)
            level = 1'b0;
    end

    assign tx_out  = level ^ cfg_invert;
    assign tx_done = done_q;

    // R1: an accepting transmitter sits on an idle line
    assert_idle_line_when_ready_R1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (tx_out == ~cfg_invert));

    // R11: readiness implies the transmitter is on
    assert_ready_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_enabled);

    // R12: completion is a single-cycle pulse
    assert_done_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R12: completion returns the block to the idle state
    assert_done_then_idle_R12: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (state == ST_IDLE));

    // R9: a break frame never shows a high line level
    assert_break_holds_low_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && flags_q.brk) |-> (tx_out == cfg_invert));

endmodule

// File: tb/sim_async_frame_tx.sv
module sim_async_frame_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        baud_tick;
    logic        tx_en_set;
    logic [3:0]  cfg_len_code;
    logic [1:0]  cfg_parity;
    logic [1:0]  cfg_stop;
    logic        cfg_msb_first;
    logic        cfg_invert;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_data;
    logic        in_break;
    logic        in_tri_after;
    logic        in_dis_after;
    logic        tx_out;
    logic        tx_oe;
    logic        tx_done;
    logic        tx_enabled;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_frame_tx u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en_set(tx_en_set),
        .cfg_len_code(cfg_len_code), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_break(in_break), .in_tri_after(in_tri_after), .in_dis_after(in_dis_after),
        .tx_out(tx_out), .tx_oe(tx_oe), .tx_done(tx_done), .tx_enabled(tx_enabled)
    );

    // tick generator, updated just after each rising edge
    initial baud_tick = 1'b1;
    always @(posedge clk) begin
        #1;
        tick_cnt  = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        baud_tick = (tick_cnt == 0);
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // observe n baud ticks, each sampled on the negedge before its rising edge
    task automatic expect_seg(input logic v, input int n, input string tag);
        int   bad = 0;
        logic got = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!baud_tick) @(negedge clk);
            if (tx_out !== (v ^ cfg_invert)) begin
                bad++;
                got = tx_out;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s line got %b expected %b", tag, got, v ^ cfg_invert);
        end
    endtask

    function automatic int len_of(input logic [3:0] c);
        return (c >= 4'd1 && c <= 4'd13) ? int'(c) + 3 : 8;
    endfunction

    task automatic run_frame(input string tag, input logic [15:0] d, input logic [3:0] lc,
                             input logic [1:0] pc, input logic [1:0] sc, input bit msb,
                             input bit brk, input bit tri_f, input bit dis_f);
        int   nb;
        logic b;
        logic p;
        nb = len_of(lc);
        @(negedge clk);
        cfg_len_code = lc; cfg_parity = pc; cfg_stop = sc; cfg_msb_first = msb;
        in_data = d; in_break = brk; in_tri_after = tri_f; in_dis_after = dis_f;
        check({tag, " ready before send"}, 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        expect_seg(1'b0, 16, {tag, " start"});
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            b = msb ? d[nb-1-i] : d[i];
            p = p ^ b;
            expect_seg(brk ? 1'b0 : b, 16, $sformatf("%s data bit %0d", tag, i));
        end
        if (pc == 2'd2 || pc == 2'd3)
            expect_seg(brk ? 1'b0 : (p ^ (pc == 2'd3)), 16, {tag, " parity"});
        expect_seg(brk ? 1'b0 : 1'b1, 8 * (int'(sc) + 1), {tag, " stop"});
        @(negedge clk);
        check({tag, " R12 done pulse"}, 32'(tx_done), 32'd1);
        check({tag, " R10 oe after frame"}, 32'(tx_oe), 32'(!tri_f));
        check({tag, " R11 enable after frame"}, 32'(tx_enabled), 32'(!dis_f));
        @(negedge clk);
        check({tag, " R12 done drops"}, 32'(tx_done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset line", 32'(tx_out), 32'd1);
        check("R1 reset oe", 32'(tx_oe), 32'd1);
        check("R1 reset enabled", 32'(tx_enabled), 32'd0);
        check("R1 reset ready", 32'(in_ready), 32'd0);
        check("R1 reset done", 32'(tx_done), 32'd0);
    endtask

    task automatic t_disabled_ignore(input string tag);
        int bad = 0;
        @(negedge clk);
        in_data = 16'h0000; in_valid = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tx_out !== ~cfg_invert || in_ready !== 1'b0) bad++;
        end
        in_valid = 1'b0;
        check({tag, " R11 valid ignored while disabled"}, 32'(bad), 32'd0);
        tx_en_set = 1'b1;
        @(negedge clk);
        tx_en_set = 1'b0;
        check({tag, " R11 re-enabled"}, 32'(tx_enabled), 32'd1);
        check({tag, " R11 ready after enable"}, 32'(in_ready), 32'd1);
    endtask

    task automatic t_invert_idle();
        @(negedge clk);
        cfg_invert = 1'b1;
        @(negedge clk);
        check("R8 inverted idle", 32'(tx_out), 32'd0);
        run_frame("R8 inverted frame", 16'h0036, 4'd5, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_invert = 1'b0;
        @(negedge clk);
        check("R8 idle restored", 32'(tx_out), 32'd1);
    endtask

    task automatic t_tristate();
        run_frame("R10 tristate frame", 16'h005A, 4'd5, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 oe stays low", 32'(tx_oe), 32'd0);
        run_frame("R10 next frame", 16'h0003, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_slow_ticks();
        @(negedge clk);
        tick_div = 3;
        repeat (4) @(negedge clk);
        run_frame("R6 gapped ticks", 16'h0096, 4'd5, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick_div = 1;
    endtask

    initial begin
        rst = 1'b1; tx_en_set = 1'b0; in_valid = 1'b0; in_data = '0;
        in_break = 1'b0; in_tri_after = 1'b0; in_dis_after = 1'b0;
        cfg_len_code = 4'd5; cfg_parity = 2'd0; cfg_stop = 2'd1;
        cfg_msb_first = 1'b0; cfg_invert = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        t_reset();
        t_disabled_ignore("first");
        run_frame("R1 R2 8-bit lsb", 16'h00A5, 4'd5, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R2 R4 4-bit even", 16'h000B, 4'd1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R2 R4 R5 16-bit odd two-stop", 16'hC3A5, 4'd13, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R3 R5 code0 half-stop", 16'h01F3, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R3 R4 R5 code15 rsvd-parity 1.5-stop", 16'hFF6C, 4'd15, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R7 msb-first 6-bit", 16'h000D, 4'd3, 2'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame("R7 msb-first 16-bit", 16'h8001, 4'd13, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        t_invert_idle();
        run_frame("R9 break", 16'h00FF, 4'd5, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        t_tristate();
        run_frame("R11 disable after", 16'h0055, 4'd5, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        t_disabled_ignore("after disable");
        t_slow_ticks();

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule